// File: doc/BRIEF.md
# Sliding Endpoint Buffer Allocator

This block divides one shared packet buffer among a fixed number of endpoint slots. Each slot has a configuration register that holds a size code, a single-or-double bank choice, an enable bit and an allocate bit. Allocated slots are packed with no gaps, in slot-number order. The start address of a slot is therefore the total footprint of every allocated slot with a lower number. Software is expected to reserve slots from the lowest number upward. The block still gives a defined result for any order of writes.

Setting or clearing the allocate bit of a slot shifts the regions of all allocated slots above it. The block flags that the contents of those slots are lost, and raises a one-cycle pulse for each slot that moved. It also reports, per slot, whether the region fits inside the buffer, and raises a summary overflow flag when one does not. A lookup port turns a slot number, a bank select and a byte offset into a physical buffer address. It reports an error when the request does not land inside a usable region.

Top module: `ep_buf_alloc`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `alloc_vec`, `en_vec`, `slid_vec`, `valid_vec`, `cfg_ok_vec` and `overflow` are all zero, `lk_err` is 1 and `lk_addr` is 0.
- R2: Size code c (3 bits) stands for 8<<c bytes, so codes 0..6 give 8..512 bytes and code 7 gives 1024 bytes. The footprint of a slot is its size, doubled when `cfg_dbl`=1. The base address of a slot is the sum of the footprints of all allocated slots with lower numbers.
- R3: A write that sets the allocate bit of slot k moves every allocated slot above k up by the footprint of k. In the cycle after that write, each of those slots shows `slid_vec`=1 and `valid_vec`=0. The slid pulse then returns to 0 on the next cycle, provided no further write moves the slot.
- R4: A write that clears the allocate bit of slot k moves every allocated slot above k down by the footprint of k, with the same slid and valid behaviour as R3. Slots below k keep their base address and their valid flag.
- R5: A write that clears only the enable bit of a slot leaves that slot's allocate bit, base address and valid flag unchanged. `en_vec` shows the enable bits.
- R6: `cfg_ok_vec[k]` is 1 exactly when slot k is allocated and its region ends at or below the buffer size. `overflow` is 1 when any allocated slot does not fit. A region that ends exactly at the buffer size fits.
- R7: A slot that goes from free to allocated and fits shows `valid_vec`=1 in the cycle after the write. A freed slot, or a slot that does not fit, shows `valid_vec`=0.
- R8: A lookup presented in one cycle returns, in the next cycle, `lk_err`=0 and `lk_addr` = base + (`lk_bank` ? size : 0) + `lk_off`, measured against the configuration registered at that edge.
- R9: A lookup returns `lk_err`=1 and `lk_addr`=0 in any of these cases: the slot index is at or above the slot count; the slot is not allocated; the slot does not fit; bank 1 is requested on a single-bank slot; or the offset is at or above the slot size.
- R10: A write to a slot index at or above the slot count changes no state. A cycle without a write changes no allocate bit and raises no slid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write the configuration of slot `cfg_slot` |
| cfg_slot | input | SLOT_W | Slot index to write |
| cfg_code | input | 3 | Size code to write |
| cfg_dbl | input | 1 | Double-bank select to write |
| cfg_en | input | 1 | Enable bit to write |
| cfg_alloc | input | 1 | Allocate bit to write |
| lk_slot | input | SLOT_W | Lookup slot index |
| lk_bank | input | 1 | Lookup bank (0 or 1) |
| lk_off | input | ADDR_W | Lookup byte offset inside the bank |
| lk_addr | output | ADDR_W | Registered physical buffer address |
| lk_err | output | 1 | Registered lookup error |
| en_vec | output | NUM_SLOTS | Enable bit of each slot |
| alloc_vec | output | NUM_SLOTS | Allocate bit of each slot |
| cfg_ok_vec | output | NUM_SLOTS | Slot is allocated and fits |
| valid_vec | output | NUM_SLOTS | Buffered data of the slot is intact |
| slid_vec | output | NUM_SLOTS | One-cycle pulse: the slot's region moved |
| overflow | output | 1 | Some allocated slot does not fit |

## Verification
The bench builds the block with its defaults: 7 slots and an 832-byte buffer. These values let one sequence fill the buffer to exactly 832 bytes and then overflow it with a single 8-byte slot. Freeing a lower slot then pulls that overflowing slot back inside the buffer. Because the slot index is 3 bits wide and there are 7 slots, index 7 can be driven to exercise the out-of-range write and lookup paths. A 512-byte double-bank slot exceeds the buffer on its own, while its single-bank form fits.

// File: rtl/ep_alloc_pkg.sv
`timescale 1ns/1ps
package ep_alloc_pkg;
  localparam int CODE_W = 3;
  localparam int MAX_BYTES = 8 << ((1 << CODE_W) - 1);

  typedef struct packed {
    logic              alloc;
    logic              en;
    logic              dbl;
    logic [CODE_W-1:0] code;
  } slot_cfg_t;

  function automatic int unsigned code_bytes(input logic [CODE_W-1:0] code);
    return 32'd8 << code;
  endfunction
endpackage

// File: rtl/ep_slot_regs.sv
`timescale 1ns/1ps
module ep_slot_regs
  import ep_alloc_pkg::*;
#(
  parameter int NUM_SLOTS = 7,
  parameter int SLOT_W    = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [SLOT_W-1:0]             wr_slot,
  input  slot_cfg_t                     wr_cfg,
  output slot_cfg_t [NUM_SLOTS-1:0]     cfg_q,
  output slot_cfg_t [NUM_SLOTS-1:0]     cfg_nx
);
  logic in_range;
  assign in_range = {1'b0, wr_slot} < (SLOT_W+1)'(NUM_SLOTS);

  always_comb begin
    cfg_nx = cfg_q;
    if (wr_en && in_range) cfg_nx[wr_slot] = wr_cfg;
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_nx;
  end
endmodule

// File: rtl/ep_layout.sv
`timescale 1ns/1ps
module ep_layout
  import ep_alloc_pkg::*;
#(
  parameter int NUM_SLOTS = 7,
  parameter int BUF_BYTES = 832,
  parameter int SUM_W     = 14
) (
  input  slot_cfg_t [NUM_SLOTS-1:0]            cfg,
  output logic      [NUM_SLOTS-1:0][SUM_W-1:0] base,
  output logic      [NUM_SLOTS-1:0]            fit
);
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(BUF_BYTES);

  logic [NUM_SLOTS:0][SUM_W-1:0] run;
  assign run[0] = '0;

  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
    logic [SUM_W-1:0] foot;
    assign foot = cfg[gi].alloc
                ? SUM_W'(code_bytes(cfg[gi].code) << cfg[gi].dbl) : '0;
    assign run[gi+1] = run[gi] + foot;
    assign base[gi]  = run[gi];
    assign fit[gi]   = !cfg[gi].alloc || (run[gi+1] <= LIMIT);
  end
endmodule

// File: rtl/ep_slot_flags.sv
`timescale 1ns/1ps
module ep_slot_flags
  import ep_alloc_pkg::*;
#(
  parameter int NUM_SLOTS = 7,
  parameter int SUM_W     = 14
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  slot_cfg_t [NUM_SLOTS-1:0]            cfg_q,
  input  slot_cfg_t [NUM_SLOTS-1:0]            cfg_nx,
  input  logic      [NUM_SLOTS-1:0][SUM_W-1:0] base_cur,
  input  logic      [NUM_SLOTS-1:0][SUM_W-1:0] base_nx,
  input  logic      [NUM_SLOTS-1:0]            fit_nx,
  output logic      [NUM_SLOTS-1:0]            slid,
  output logic      [NUM_SLOTS-1:0]            valid,
  output logic      [NUM_SLOTS-1:0]            ok,
  output logic                                 overflow
);
  logic [NUM_SLOTS-1:0] bad_nx;

  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_flag
    logic moved, usable, slid_r, valid_r, ok_r;
    assign moved  = cfg_q[gi].alloc && cfg_nx[gi].alloc
                 && (base_cur[gi] != base_nx[gi]);
    assign usable = cfg_nx[gi].alloc && fit_nx[gi];
    assign bad_nx[gi] = cfg_nx[gi].alloc && !fit_nx[gi];

    always_ff @(posedge clk) begin
      if (rst) begin
        slid_r  <= 1'b0;
        valid_r <= 1'b0;
        ok_r    <= 1'b0;
      end else begin
        slid_r <= moved;
        ok_r   <= usable;
        if (!usable)               valid_r <= 1'b0;
        else if (!cfg_q[gi].alloc) valid_r <= 1'b1;
        else if (moved)            valid_r <= 1'b0;
      end
    end

    assign slid[gi]  = slid_r;
    assign valid[gi] = valid_r;
    assign ok[gi]    = ok_r;
  end

  always_ff @(posedge clk) begin
    if (rst) overflow <= 1'b0;
    else     overflow <= |bad_nx;
  end
endmodule

// File: rtl/ep_lookup.sv
`timescale 1ns/1ps
module ep_lookup
  import ep_alloc_pkg::*;
#(
  parameter int NUM_SLOTS = 7,
  parameter int SLOT_W    = 3,
  parameter int ADDR_W    = 10,
  parameter int SUM_W     = 14
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  slot_cfg_t [NUM_SLOTS-1:0]            cfg,
  input  logic      [NUM_SLOTS-1:0][SUM_W-1:0] base,
  input  logic      [NUM_SLOTS-1:0]            ok,
  input  logic      [SLOT_W-1:0]               lk_slot,
  input  logic                                 lk_bank,
  input  logic      [ADDR_W-1:0]               lk_off,
  output logic      [ADDR_W-1:0]               lk_addr,
  output logic                                 lk_err
);
  logic              in_range, bad;
  logic [SLOT_W-1:0] idx;
  slot_cfg_t         sel;
  logic [SUM_W-1:0]  sz, off_w, sum;

  always_comb begin
    in_range = {1'b0, lk_slot} < (SLOT_W+1)'(NUM_SLOTS);
    idx      = in_range ? lk_slot : '0;
    sel      = cfg[idx];
    sz       = SUM_W'(code_bytes(sel.code));
    off_w    = SUM_W'(lk_off);
    bad      = !in_range || !sel.alloc || !ok[idx]
             || (lk_bank && !sel.dbl) || (off_w >= sz);
    sum      = base[idx] + (lk_bank ? sz : '0) + off_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_err  <= 1'b1;
      lk_addr <= '0;
    end else begin
      lk_err  <= bad;
      lk_addr <= bad ? '0 : ADDR_W'(sum);
    end
  end
endmodule

// File: rtl/ep_buf_alloc.sv
`timescale 1ns/1ps
module ep_buf_alloc
  import ep_alloc_pkg::*;
#(
  parameter  int NUM_SLOTS = 7,
  parameter  int BUF_BYTES = 832,
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int ADDR_W    = $clog2(BUF_BYTES),
  localparam int SUM_W     = $clog2(NUM_SLOTS * 2 * MAX_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [SLOT_W-1:0]    cfg_slot,
  input  logic [CODE_W-1:0]    cfg_code,
  input  logic                 cfg_dbl,
  input  logic                 cfg_en,
  input  logic                 cfg_alloc,
  input  logic [SLOT_W-1:0]    lk_slot,
  input  logic                 lk_bank,
  input  logic [ADDR_W-1:0]    lk_off,
  output logic [ADDR_W-1:0]    lk_addr,
  output logic                 lk_err,
  output logic [NUM_SLOTS-1:0] en_vec,
  output logic [NUM_SLOTS-1:0] alloc_vec,
  output logic [NUM_SLOTS-1:0] cfg_ok_vec,
  output logic [NUM_SLOTS-1:0] valid_vec,
  output logic [NUM_SLOTS-1:0] slid_vec,
  output logic                 overflow
);
  slot_cfg_t                            wr_cfg;
  slot_cfg_t [NUM_SLOTS-1:0]            cfg_q, cfg_nx;
  logic      [NUM_SLOTS-1:0][SUM_W-1:0] base_cur, base_nx;
  logic      [NUM_SLOTS-1:0]            fit_cur, fit_nx;

  assign wr_cfg = '{alloc: cfg_alloc, en: cfg_en, dbl: cfg_dbl, code: cfg_code};

  ep_slot_regs #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_slot(cfg_slot),
    .wr_cfg(wr_cfg), .cfg_q(cfg_q), .cfg_nx(cfg_nx));

  ep_layout #(.NUM_SLOTS(NUM_SLOTS), .BUF_BYTES(BUF_BYTES), .SUM_W(SUM_W)) u_lay_cur (
    .cfg(cfg_q), .base(base_cur), .fit(fit_cur));

  ep_layout #(.NUM_SLOTS(NUM_SLOTS), .BUF_BYTES(BUF_BYTES), .SUM_W(SUM_W)) u_lay_nxt (
    .cfg(cfg_nx), .base(base_nx), .fit(fit_nx));

  ep_slot_flags #(.NUM_SLOTS(NUM_SLOTS), .SUM_W(SUM_W)) u_flags (
    .clk(clk), .rst(rst), .cfg_q(cfg_q), .cfg_nx(cfg_nx),
    .base_cur(base_cur), .base_nx(base_nx), .fit_nx(fit_nx),
    .slid(slid_vec), .valid(valid_vec), .ok(cfg_ok_vec), .overflow(overflow));

  ep_lookup #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .SUM_W(SUM_W)) u_look (
    .clk(clk), .rst(rst), .cfg(cfg_q), .base(base_cur), .ok(cfg_ok_vec & fit_cur),
    .lk_slot(lk_slot), .lk_bank(lk_bank), .lk_off(lk_off),
    .lk_addr(lk_addr), .lk_err(lk_err));

  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_out
    assign en_vec[gi]    = cfg_q[gi].en;
    assign alloc_vec[gi] = cfg_q[gi].alloc;
  end
endmodule

// File: rtl/ep_buf_alloc_chk.sv
`timescale 1ns/1ps
module ep_buf_alloc_chk #(
  parameter  int NUM_SLOTS = 7,
  parameter  int BUF_BYTES = 832,
  localparam int ADDR_W    = $clog2(BUF_BYTES)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_we,
  input logic [ADDR_W-1:0]    lk_addr,
  input logic                 lk_err,
  input logic [NUM_SLOTS-1:0] alloc_vec,
  input logic [NUM_SLOTS-1:0] cfg_ok_vec,
  input logic [NUM_SLOTS-1:0] valid_vec,
  input logic [NUM_SLOTS-1:0] slid_vec,
  input logic                 overflow
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(BUF_BYTES);

  a_r3_slid_only_alloc: assert property (@(posedge clk) disable iff (rst)
    (slid_vec & ~alloc_vec) == '0);

  a_r3_slid_clears_valid: assert property (@(posedge clk) disable iff (rst)
    (slid_vec & valid_vec) == '0);

  a_r6_ok_within_alloc: assert property (@(posedge clk) disable iff (rst)
    (cfg_ok_vec & ~alloc_vec) == '0);

  a_r6_overflow_flag: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (cfg_ok_vec != alloc_vec));

  a_r7_valid_needs_ok: assert property (@(posedge clk) disable iff (rst)
    (valid_vec & ~cfg_ok_vec) == '0);

  a_r8_addr_in_buffer: assert property (@(posedge clk) disable iff (rst)
    !lk_err |-> ({1'b0, lk_addr} < LIMIT));

  a_r9_err_zero_addr: assert property (@(posedge clk) disable iff (rst)
    lk_err |-> (lk_addr == '0));

  a_r10_idle_no_change: assert property (@(posedge clk) disable iff (rst)
    (!$past(cfg_we) && !$past(rst)) |-> ($stable(alloc_vec) && slid_vec == '0));
endmodule

bind ep_buf_alloc ep_buf_alloc_chk #(.NUM_SLOTS(NUM_SLOTS), .BUF_BYTES(BUF_BYTES)) u_chk (.*);

// File: tb/ep_buf_alloc_bench.sv
`timescale 1ns/1ps
module ep_buf_alloc_bench;
  localparam int N = 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_slot = '0, cfg_code = '0;
  logic       cfg_dbl = 1'b0, cfg_en = 1'b0, cfg_alloc = 1'b0;
  logic [2:0] lk_slot = '0;
  logic       lk_bank = 1'b0;
  logic [9:0] lk_off = '0;
  logic [9:0] lk_addr;
  logic       lk_err, overflow;
  logic [N-1:0] en_vec, alloc_vec, cfg_ok_vec, valid_vec, slid_vec;

  always #4 clk = ~clk;

  ep_buf_alloc u_ep_buf_alloc (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [2:0] slot; logic [2:0] code; logic dbl; logic en; logic al;
    logic [2:0] chk; logic [9:0] base;
    logic [6:0] slid; logic [6:0] valid; logic [6:0] ok; logic ovf;
  } vec_t;

  localparam vec_t VEC [0:10] = '{
    '{3'd0,3'd2,1'b0,1'b1,1'b1, 3'd0,10'd0,   7'b0000000,7'b0000001,7'b0000001,1'b0},
    '{3'd1,3'd3,1'b1,1'b1,1'b1, 3'd1,10'd32,  7'b0000000,7'b0000011,7'b0000011,1'b0},
    '{3'd2,3'd1,1'b0,1'b1,1'b1, 3'd2,10'd160, 7'b0000000,7'b0000111,7'b0000111,1'b0},
    '{3'd0,3'd2,1'b0,1'b1,1'b0, 3'd2,10'd128, 7'b0000110,7'b0000000,7'b0000110,1'b0},
    '{3'd0,3'd2,1'b0,1'b1,1'b1, 3'd1,10'd32,  7'b0000110,7'b0000001,7'b0000111,1'b0},
    '{3'd1,3'd3,1'b1,1'b0,1'b1, 3'd1,10'd32,  7'b0000000,7'b0000001,7'b0000111,1'b0},
    '{3'd3,3'd5,1'b1,1'b1,1'b1, 3'd3,10'd176, 7'b0000000,7'b0001001,7'b0001111,1'b0},
    '{3'd4,3'd4,1'b0,1'b1,1'b1, 3'd4,10'd688, 7'b0000000,7'b0011001,7'b0011111,1'b0},
    '{3'd5,3'd1,1'b0,1'b1,1'b1, 3'd5,10'd816, 7'b0000000,7'b0111001,7'b0111111,1'b0},
    '{3'd6,3'd0,1'b0,1'b1,1'b1, 3'd5,10'd816, 7'b0000000,7'b0111001,7'b0111111,1'b1},
    '{3'd2,3'd1,1'b0,1'b0,1'b0, 3'd6,10'd816, 7'b1111000,7'b0000001,7'b1111011,1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int s, input int code, input int dbl, input int en, input int al);
    cfg_slot = 3'(s); cfg_code = 3'(code); cfg_dbl = dbl[0];
    cfg_en = en[0]; cfg_alloc = al[0]; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input int s, input int bank, input int off, output int a, output int e);
    lk_slot = 3'(s); lk_bank = bank[0]; lk_off = 10'(off);
    @(negedge clk);
    a = int'(lk_addr); e = int'(lk_err);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int a, e;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 alloc", int'(alloc_vec), 0);
    check("R1 valid", int'(valid_vec), 0);
    check("R1 ok", int'(cfg_ok_vec), 0);
    check("R1 err", int'(lk_err), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 overflow", int'(overflow), 0);
    check("R1 slid", int'(slid_vec), 0);

    for (int i = 0; i < 11; i++) begin
      wr(VEC[i].slot, VEC[i].code, VEC[i].dbl, VEC[i].en, VEC[i].al);
      check($sformatf("R3/R4 slid row%0d", i), int'(slid_vec), int'(VEC[i].slid));
      check($sformatf("R7 valid row%0d", i), int'(valid_vec), int'(VEC[i].valid));
      check($sformatf("R6 ok row%0d", i), int'(cfg_ok_vec), int'(VEC[i].ok));
      check($sformatf("R6 overflow row%0d", i), int'(overflow), int'(VEC[i].ovf));
      look(VEC[i].chk, 0, 0, a, e);
      check($sformatf("R2 base row%0d", i), a, int'(VEC[i].base));
      check($sformatf("R2 err row%0d", i), e, 0);
    end

    // R3 pulse lasts one cycle
    check("R3 slid drops", int'(slid_vec), 0);
    // R5 enable bits kept separate from allocation
    check("R5 en_vec", int'(en_vec), 7'b1111001);
    check("R5 alloc_vec", int'(alloc_vec), 7'b1111011);
    // R8 address arithmetic
    look(3, 1, 5, a, e);  check("R8 s3 bank1", a, 421); check("R8 s3 err", e, 0);
    look(1, 1, 63, a, e); check("R8 s1 bank1", a, 159);
    look(6, 0, 7, a, e);  check("R8 s6 last byte", a, 823);
    // R9 errors
    look(6, 0, 8, a, e);  check("R9 offset", e, 1); check("R9 offset addr", a, 0);
    look(0, 1, 0, a, e);  check("R9 bank1 single", e, 1);
    look(2, 0, 0, a, e);  check("R9 unallocated", e, 1);
    look(7, 0, 0, a, e);  check("R9 index range", e, 1);
    // R10 write to out-of-range index
    wr(7, 0, 0, 1, 1);
    check("R10 alloc kept", int'(alloc_vec), 7'b1111011);
    check("R10 slid", int'(slid_vec), 0);
    check("R10 valid", int'(valid_vec), 7'b0000001);

    // R1 reset again mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 reset alloc", int'(alloc_vec), 0);
    check("R1 reset en", int'(en_vec), 0);
    look(0, 0, 0, a, e);  check("R9 after reset", e, 1);

    // R6 largest code double overflows alone
    wr(0, 6, 1, 1, 1);
    check("R6 big overflow", int'(overflow), 1);
    check("R6 big ok", int'(cfg_ok_vec), 0);
    check("R7 big valid", int'(valid_vec), 0);
    look(0, 0, 0, a, e);  check("R9 not fitting", e, 1);
    wr(0, 6, 0, 1, 1);
    check("R6 single fits", int'(overflow), 0);
    check("R6 single ok", int'(cfg_ok_vec), 1);
    look(0, 0, 511, a, e); check("R2 512 last byte", a, 511);
    look(0, 0, 512, a, e); check("R9 512 past end", e, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule